// File: doc/BRIEF.md
# Oversampling Serial Receiver with Majority Voting

This block recovers 8-bit characters from one asynchronous serial line. It runs on the system clock, and it acts only in cycles where an external enable pulse marks one oversample. That pulse comes at 16 times the bit rate. The line is first synchronized. A possible start bit is qualified by a run of low samples before the block commits to a frame. Each data bit and the stop bit is then decided by a two-of-three majority over three samples near the middle of the bit.

A recovered byte appears on a data output, together with a strobe that lasts one clock and a framing flag. The framing flag is set when the stop bit votes low. After each frame, the receiver does not accept a new start until it has seen the line high. This keeps a held-low line (a break) from being read as a stream of frames.

Top module: `uart_os_rx`

## Requirements
- R1: After a synchronous active-high reset, `rx_valid` is 0, `rx_data` is 0x00 and `framing_error` is 0. No strobe appears while the line stays high.
- R2: Phase 0 is the first oversample that reads low after the line was seen high. A start is accepted only if the samples at phases 1 through 8 are also low. A high sample anywhere in phases 1 to 8 drops the attempt with no output. So a low run of 5 or 8 samples produces no character.
- R3: After a dropped start, the receiver is armed at once. A correct frame that follows it is received in full.
- R4: Data bit k (k = 0..7) spans phases 16(k+1) to 16(k+1)+15, counted from phase 0. The data bits are LSB first, with no parity. Every byte value 0x00 to 0xFF is recovered exactly.
- R5: Each bit is the majority of the samples at offsets 7, 8 and 9 within its own period. If one of the three disagrees, the bit keeps the value of the other two. If two disagree, the bit takes their value.
- R6: Samples at offsets 0 to 6 and 10 to 15 of a data bit have no effect on the recovered byte.
- R7: `rx_valid` is high for exactly one clock per accepted frame. `rx_data` changes only in the cycle where `rx_valid` is high.
- R8: The stop bit spans phases 144 to 159 and is voted on offsets 7, 8 and 9 in the same way. A low vote still delivers the byte, with `framing_error` = 1. A high vote gives `framing_error` = 0. The flag holds until the next strobe.
- R9: After the stop decision, no start is accepted until one oversample reads the line high. A line held low after a frame with a framing error produces no further characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-clock oversample enable, at 16 times the bit rate |
| rxd | input | 1 | Asynchronous serial input, idles high |
| rx_data | output | 8 | Last recovered character |
| rx_valid | output | 1 | One-clock strobe marking a new character |
| framing_error | output | 1 | Stop bit of the last character voted low |

## Verification
The byte delivery and the framing verdict are decided in the same clock: the one where the stop vote completes. Frames are sent with a stop bit driven low, and the bench checks that the strobe, the correct byte and a set framing flag all appear together. The next clean frame must then clear the flag. The same collision is then extended by holding the line low across the re-arm point. That point is where a careless receiver would take the continued low as a fresh start. The bench requires that no extra strobe appears.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

    typedef enum logic [1:0] {
        RX_WAIT_HIGH = 2'd0,
        RX_IDLE      = 2'd1,
        RX_START     = 2'd2,
        RX_DATA      = 2'd3
    } rx_state_e;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/rx_phase_timer.sv
module rx_phase_timer #(
    parameter int OSR  = 16,
    localparam int PH_W = $clog2(OSR)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            restart,
    output logic [PH_W-1:0] phase
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);

    logic [PH_W-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        if (tick) begin
            if (restart)                phase_d = PH_W'(1);
            else if (phase_q == PH_LAST) phase_d = '0;
            else                        phase_d = phase_q + PH_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_d;
    end

    assign phase = phase_q;

    // R4
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(phase_q));
endmodule

// File: rtl/rx_majority.sv
module rx_majority #(
    parameter int VOTES = 3,
    localparam int CNT_W = $clog2(VOTES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic smp_en,
    input  logic smp_last,
    input  logic din,
    output logic decision
);
    logic [CNT_W-1:0] ones_d, ones_q;
    logic [CNT_W:0]   total;

    always_comb begin
        total    = {1'b0, ones_q} + {{CNT_W{1'b0}}, din};
        decision = total > (CNT_W+1)'(VOTES / 2);
        ones_d   = ones_q;
        if (clr || (smp_en && smp_last)) ones_d = '0;
        else if (smp_en)                 ones_d = total[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) ones_q <= '0;
        else     ones_q <= ones_d;
    end

    // R5
    ones_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ones_q < CNT_W'(VOTES));
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_os_rx_pkg::*;
#(
    parameter int OSR       = 16,
    parameter int DATA_BITS = 8,
    parameter int VOTES     = 3,
    parameter int SYNC_FF   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 rxd,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 framing_error
);
    localparam int PH_W      = $clog2(OSR);
    localparam int BIT_W     = $clog2(DATA_BITS + 1);
    localparam int START_LOW = OSR / 2;
    localparam int VOTE_LO   = OSR / 2 - 1;
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(OSR - 1);
    localparam logic [PH_W-1:0]  WIN_LO  = PH_W'(VOTE_LO);
    localparam logic [PH_W-1:0]  WIN_HI  = PH_W'(VOTE_LO + VOTES - 1);
    localparam logic [PH_W-1:0]  CHK_HI  = PH_W'(START_LOW);
    localparam logic [BIT_W-1:0] NB      = BIT_W'(DATA_BITS);

    typedef struct packed {
        rx_state_e            st;
        logic [BIT_W-1:0]     nbit;
        logic [DATA_BITS-1:0] shift;
        logic [DATA_BITS-1:0] data;
        logic                 valid;
        logic                 ferr;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    logic            line_s;
    logic [PH_W-1:0] phase;
    logic            tmr_restart;
    logic            vote_en, vote_last, vote_clr, vote_bit;
    logic            in_win, win_last, start_chk;

    rx_line_sync #(.STAGES(SYNC_FF)) u_sync (
        .clk (clk), .rst (rst), .din (rxd), .dout (line_s)
    );

    rx_phase_timer #(.OSR(OSR)) u_timer (
        .clk (clk), .rst (rst), .tick (tick),
        .restart (tmr_restart), .phase (phase)
    );

    rx_majority #(.VOTES(VOTES)) u_vote (
        .clk (clk), .rst (rst), .clr (vote_clr), .smp_en (vote_en),
        .smp_last (vote_last), .din (line_s), .decision (vote_bit)
    );

    always_comb begin
        in_win    = (phase >= WIN_LO) && (phase <= WIN_HI);
        win_last  = (phase == WIN_HI);
        start_chk = (phase != '0) && (phase <= CHK_HI);
    end

    always_comb begin
        r_d         = r_q;
        r_d.valid   = 1'b0;
        tmr_restart = 1'b0;
        vote_en     = 1'b0;
        vote_last   = 1'b0;
        vote_clr    = 1'b0;
        if (tick) begin
            case (r_q.st)
                RX_WAIT_HIGH: begin
                    if (line_s) r_d.st = RX_IDLE;
                end
                RX_IDLE: begin
                    if (!line_s) begin
                        r_d.st      = RX_START;
                        tmr_restart = 1'b1;
                        vote_clr    = 1'b1;
                    end
                end
                RX_START: begin
                    if (start_chk && line_s) begin
                        r_d.st = RX_IDLE;
                    end else if (phase == PH_LAST) begin
                        r_d.st   = RX_DATA;
                        r_d.nbit = '0;
                    end
                end
                RX_DATA: begin
                    if (in_win) begin
                        vote_en = 1'b1;
                        if (win_last) begin
                            vote_last = 1'b1;
                            if (r_q.nbit < NB) begin
                                r_d.shift = {vote_bit, r_q.shift[DATA_BITS-1:1]};
                                r_d.nbit  = r_q.nbit + BIT_W'(1);
                            end else begin
                                r_d.data  = r_q.shift;
                                r_d.valid = 1'b1;
                                r_d.ferr  = ~vote_bit;
                                r_d.st    = RX_WAIT_HIGH;
                            end
                        end
                    end
                end
                default: r_d.st = RX_WAIT_HIGH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st    <= RX_WAIT_HIGH;
            r_q.nbit  <= '0;
            r_q.shift <= '0;
            r_q.data  <= '0;
            r_q.valid <= 1'b0;
            r_q.ferr  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_data       = r_q.data;
    assign rx_valid      = r_q.valid;
    assign framing_error = r_q.ferr;

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable(rx_data));

    // R9
    rearm_wait_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (r_q.st == RX_WAIT_HIGH));

    // R2
    start_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && r_q.st == RX_START && start_chk && line_s) |=> (r_q.st == RX_IDLE));
endmodule

// File: tb/uart_os_rx_tb.sv
module uart_os_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 3;
    localparam int WATCHDOG   = 199000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       framing_error;

    int n_vec = 0;
    int n_bad = 0;
    int vcnt  = 0;
    logic [7:0] last_d = 8'h00;
    logic       last_fe = 1'b0;
    int tick_cnt = 0;

    uart_os_rx u_dut (
        .clk (clk), .rst (rst), .tick (tick), .rxd (rxd),
        .rx_data (rx_data), .rx_valid (rx_valid), .framing_error (framing_error)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        tick_cnt <= (tick_cnt == TICK_DIV-1) ? 0 : tick_cnt + 1;
        tick     <= (tick_cnt == TICK_DIV-1);
    end

    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            vcnt    <= vcnt + 1;
            last_d  <= rx_data;
            last_fe <= framing_error;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic v);
        @(negedge clk);
        while (!tick) @(negedge clk);
        rxd = v;
    endtask

    task automatic put_n(input logic v, input int n);
        for (int i = 0; i < n; i++) put(v);
    endtask

    // mode 0 clean, 1 one of offsets 7..9 flipped, 2 offsets 7 and 8 flipped,
    // 3 every offset outside 7..9 flipped
    task automatic send(input logic [7:0] d, input logic stopv, input int mode, input int idle);
        put_n(1'b0, 16);
        for (int b = 0; b < 8; b++) begin
            for (int p = 0; p < 16; p++) begin
                logic v;
                v = d[b];
                if (mode == 1 && p == 7 + (b % 3)) v = ~v;
                if (mode == 2 && (p == 7 || p == 8)) v = ~v;
                if (mode == 3 && (p < 7 || p > 9)) v = ~v;
                put(v);
            end
        end
        put_n(stopv, 16);
        put_n(1'b1, idle);
    endtask

    task automatic frame_chk(input int v0, input logic [7:0] ed, input logic efe, input string tag);
        chk(vcnt == v0 + 1, {tag, " strobe count"}, vcnt - v0, 1);
        chk(last_d == ed, {tag, " data"}, last_d, ed);
        chk(last_fe == efe, {tag, " framing flag"}, last_fe, efe);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int v0;
        repeat (6) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(rx_valid == 1'b0, "R1 valid", rx_valid, 0);
        chk(rx_data == 8'h00, "R1 data", rx_data, 0);
        chk(framing_error == 1'b0, "R1 flag", framing_error, 0);
        put_n(1'b1, 20);
        chk(vcnt == 0, "R1 idle line", vcnt, 0);

        // R2 short glitches rejected: 5 lows, then exactly 8 lows (phase 8 high)
        v0 = vcnt;
        put_n(1'b0, 5);  put_n(1'b1, 20);
        put_n(1'b0, 8);  put_n(1'b1, 200);
        chk(vcnt == v0, "R2 rejected starts", vcnt - v0, 0);

        // R3 clean frame right after a rejected start
        put_n(1'b0, 3);
        put_n(1'b1, 2);
        v0 = vcnt;
        send(8'h5A, 1'b1, 0, 4);
        frame_chk(v0, 8'h5A, 1'b0, "R3");

        // R4 R7 exhaustive byte sweep
        for (int d = 0; d < 256; d++) begin
            v0 = vcnt;
            send(8'(d), 1'b1, 0, 2);
            frame_chk(v0, 8'(d), 1'b0, "R4 R7 sweep");
        end

        // R5 R6 voting and ignored offsets
        for (int m = 1; m <= 3; m++) begin
            logic [7:0] pats [4];
            pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'h01; pats[3] = 8'hFE;
            for (int k = 0; k < 4; k++) begin
                v0 = vcnt;
                send(pats[k], 1'b1, m, 3);
                if (m == 1) frame_chk(v0, pats[k], 1'b0, "R5 one dissent");
                if (m == 2) frame_chk(v0, ~pats[k], 1'b0, "R5 two dissent");
                if (m == 3) frame_chk(v0, pats[k], 1'b0, "R6 outer offsets");
            end
        end

        // R8 bad stop: byte still delivered with flag, flag held
        v0 = vcnt;
        send(8'hC3, 1'b0, 0, 0);
        put_n(1'b1, 4);
        frame_chk(v0, 8'hC3, 1'b1, "R8 low stop");
        put_n(1'b1, 10);
        chk(framing_error == 1'b1, "R8 flag held", framing_error, 1);
        v0 = vcnt;
        send(8'h3E, 1'b1, 0, 3);
        frame_chk(v0, 8'h3E, 1'b0, "R8 flag cleared");

        // R9 break after bad stop: no new frames until the line goes high
        v0 = vcnt;
        send(8'h81, 1'b0, 0, 0);
        put_n(1'b0, 200);
        chk(vcnt == v0 + 1, "R9 break", vcnt - v0, 1);
        chk(last_fe == 1'b1, "R9 break flag", last_fe, 1);
        put_n(1'b1, 3);
        v0 = vcnt;
        send(8'h77, 1'b1, 0, 3);
        frame_chk(v0, 8'h77, 1'b0, "R9 after break");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule